// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block interprets the write-cycle command protocol of a parallel NOR flash model and sits directly in front of a small on-chip storage array. Every bus write carries a command byte in its low eight bits, or a data word, depending on where the sequencer is in its current command. A command register, a phase counter, a word counter for buffered writes and an 8-bit status register hold all of the protocol state.

Each bus read is served combinationally at a byte offset. The source of the returned word depends on the command register. In read-array mode it is the stored word. After a program, erase, lock, clear, status or buffered-write command it is the status byte. In identification mode it is the vendor or part code, and in query mode it is a computed query table. All state changes on the rising clock edge, and a single-cycle `wr_en` strobe marks each bus write.

A write-protect input stops every change to the array. When it is active, an attempted program or erase sets the matching error bit in the status register and leaves the array as it was.

Top module: `nor_cmd_seq`

## Requirements
- R1: A synchronous reset fills the array with 0xFF words, clears the status register to 0x00 and selects read-array mode, so that a read returns the stored word.
- R2: In the idle phase, command 0x10 or 0x40 arms a single program. The next bus write stores its full data word at the addressed word (offset divided by the bus width in bytes), and the sequencer returns to the idle phase.
- R3: Command 0x20 erases at once the whole block of BLOCK_BYTES bytes that holds the address, filling it with 0xFF. The next write 0xD0 confirms the erase and keeps status mode. The next write 0xFF returns to read-array mode. Any other value also resets the sequencer to read-array mode.
- R4: Command 0xE8 begins a buffered write. The next write gives a count, masked to its low 8*DEV_BYTES bits. The following count+1 writes are stored as data words, and a final 0xD0 confirms. A non-0xD0 write in the confirm phase resets the sequencer to read-array mode and is not stored.
- R5: Status bit 7 (ready) is set when an erase or buffered-write setup is accepted, when a program or buffered data word completes, and when an erase or lock is confirmed.
- R6: While `wp` is high the array is never modified. A blocked program or buffered data word sets status bit 4, and a blocked erase sets status bit 5.
- R7: Command 0x50 clears the status register to 0x00 and selects read-array mode. Commands 0xFF, 0xF0 and 0x00 in the idle phase also select read-array mode.
- R8: Commands 0x70 and 0x90 select status or identification reads and leave the phase idle, so the next write is taken as a command. In identification mode word index 0 reads VENDOR_CODE, index 1 reads PART_CODE and any other index reads 0. Each value is truncated to one device lane and copied into every lane.
- R9: Command 0x60 starts a lock sequence. A following 0xD0 or 0x01 completes it and sets ready. Any other value resets the sequencer to read-array mode.
- R10: While the command register holds 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte zero-extended into every lane of 8*DEV_BYTES bits across the bus word.
- R11: An unrecognised command byte in the idle phase resets the sequencer to read-array mode.
- R12: Command 0x98 enters query mode. The query bytes 0x51, 0x52 and 0x59 appear at word indices 0x10 to 0x12, and the array address width appears at index 0x27, each copied into every lane. Any later write except 0xFF leaves query mode unchanged, and 0xFF returns to read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle bus write strobe |
| addr | input | ADDR_W | Byte offset of the access, aligned to the bus width |
| wr_data | input | 8*BANK_BYTES | Write word: a command byte in bits 7:0, or data or a count |
| wp | input | 1 | Write protect for the array |
| rd_data | output | 8*BANK_BYTES | Read word selected by the current mode |

## Verification
Each command sequence is driven with its accepted continuation and with its refusing alternatives. An erase is followed by 0xD0, by 0xFF and by an unrelated byte, and a lock by 0xD0, by 0x01 and by an unrelated byte. These cases separate a confirmed completion from an abort to read-array mode and from a sequencer reset. A buffered write uses a count whose upper byte is non-zero, so a missing mask would swallow the confirm as data. It also uses a bad confirm byte, which shows that an extra word is never stored. The same program, erase and buffered write are then repeated with `wp` high, to show that the array stays unchanged and that the error bit specific to each operation is set. Identification and query reads at several indices, followed by an immediate command, show that mode selection does not use up a write phase.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [7:0] OP_NOP       = 8'h00;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_ERASE_ALT = 8'h28;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_CLRST     = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_BUFWR     = 8'hE8;
  localparam logic [7:0] OP_ALT_RESET = 8'hF0;
  localparam logic [7:0] OP_ARRAY     = 8'hFF;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_LOCK_SET  = 8'h01;

  localparam int ST_READY = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_ARG, PH_DATA, PH_CONFIRM} phase_t;
  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_IDENT, SRC_QUERY} rdsrc_t;

  function automatic rdsrc_t read_source(input logic [7:0] op);
    case (op)
      OP_PROG_A, OP_ERASE, OP_ERASE_ALT, OP_PROG_B,
      OP_CLRST, OP_LOCK, OP_STATUS, OP_BUFWR: return SRC_STATUS;
      OP_IDENT: return SRC_IDENT;
      OP_QUERY: return SRC_QUERY;
      default:  return SRC_ARRAY;
    endcase
  endfunction

  function automatic logic [7:0] query_byte(input logic [7:0] idx, input logic [7:0] size_log2);
    case (idx)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return size_log2;
      8'h2C:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             wp,
  output logic             prog_we,
  output logic             erase_we,
  output logic [7:0]       op_q,
  output logic [7:0]       status_q
);

  phase_t           ph_q, nxt_ph;
  logic [7:0]       nxt_op, nxt_st;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic             seq_reset;

  always_comb begin
    nxt_op    = op_q;
    nxt_ph    = ph_q;
    nxt_st    = status_q;
    nxt_cnt   = cnt_q;
    prog_we   = 1'b0;
    erase_we  = 1'b0;
    seq_reset = 1'b0;
    if (wr_en) begin
      case (ph_q)
        PH_IDLE: begin
          case (wr_byte)
            OP_NOP, OP_ALT_RESET, OP_ARRAY: seq_reset = 1'b1;
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              nxt_op = wr_byte;
              nxt_ph = PH_ARG;
            end
            OP_ERASE: begin
              if (wp) nxt_st[ST_ERASE_ERR] = 1'b1;
              else    erase_we = 1'b1;
              nxt_st[ST_READY] = 1'b1;
              nxt_op = wr_byte;
              nxt_ph = PH_ARG;
            end
            OP_BUFWR: begin
              nxt_st[ST_READY] = 1'b1;
              nxt_op = wr_byte;
              nxt_ph = PH_ARG;
            end
            OP_CLRST: begin
              nxt_st = '0;
              seq_reset = 1'b1;
            end
            OP_STATUS, OP_IDENT: nxt_op = wr_byte;
            default: seq_reset = 1'b1;
          endcase
        end
        PH_ARG: begin
          case (op_q)
            OP_PROG_A, OP_PROG_B: begin
              if (wp) nxt_st[ST_PROG_ERR] = 1'b1;
              else    prog_we = 1'b1;
              nxt_st[ST_READY] = 1'b1;
              nxt_ph = PH_IDLE;
            end
            OP_ERASE, OP_ERASE_ALT: begin
              if (wr_byte == OP_CONFIRM) begin
                nxt_st[ST_READY] = 1'b1;
                nxt_ph = PH_IDLE;
              end else begin
                seq_reset = 1'b1;
              end
            end
            OP_BUFWR: begin
              nxt_cnt = cnt_in;
              nxt_ph  = PH_DATA;
            end
            OP_LOCK: begin
              if (wr_byte == OP_CONFIRM || wr_byte == OP_LOCK_SET) begin
                nxt_st[ST_READY] = 1'b1;
                nxt_ph = PH_IDLE;
              end else begin
                seq_reset = 1'b1;
              end
            end
            OP_QUERY: if (wr_byte == OP_ARRAY) seq_reset = 1'b1;
            default: seq_reset = 1'b1;
          endcase
        end
        PH_DATA: begin
          if (op_q == OP_BUFWR) begin
            if (wp) nxt_st[ST_PROG_ERR] = 1'b1;
            else    prog_we = 1'b1;
            nxt_st[ST_READY] = 1'b1;
            if (cnt_q == '0) nxt_ph = PH_CONFIRM;
            nxt_cnt = cnt_q - 1'b1;
          end else begin
            seq_reset = 1'b1;
          end
        end
        default: begin
          if (op_q == OP_BUFWR && wr_byte == OP_CONFIRM) begin
            nxt_st[ST_READY] = 1'b1;
            nxt_ph = PH_IDLE;
          end else begin
            seq_reset = 1'b1;
          end
        end
      endcase
    end
    if (seq_reset) begin
      nxt_op = OP_NOP;
      nxt_ph = PH_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_NOP;
      ph_q     <= PH_IDLE;
      status_q <= '0;
      cnt_q    <= '0;
    end else begin
      op_q     <= nxt_op;
      ph_q     <= nxt_ph;
      status_q <= nxt_st;
      cnt_q    <= nxt_cnt;
    end
  end

  assert_data_phase_bufwr_R4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA || ph_q == PH_CONFIRM) |-> op_q == OP_BUFWR);

  assert_ready_after_store_R5: assert property (@(posedge clk) disable iff (rst)
    (prog_we || erase_we) |=> status_q[ST_READY]);

  assert_prog_err_from_wp_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[ST_PROG_ERR]) |-> $past(wp));

  assert_erase_err_from_wp_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[ST_ERASE_ERR]) |-> $past(wp));

  assert_clear_status_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ph_q == PH_IDLE && wr_byte == OP_CLRST) |=> (status_q == 8'h00 && op_q == OP_NOP));

  assert_mode_no_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ph_q == PH_IDLE && (wr_byte == OP_STATUS || wr_byte == OP_IDENT)) |=> ph_q == PH_IDLE);

endmodule

// File: rtl/nor_seq_store.sv
module nor_seq_store #(
  parameter int WORD_W    = 16,
  parameter int DEPTH     = 128,
  parameter int BLK_WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic                     erase,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata
);

  localparam int IDX_W   = $clog2(DEPTH);
  localparam int BLK_LOG = $clog2(BLK_WORDS);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  blk_sel;

  assign blk_sel = idx >> BLK_LOG;
  assign rdata   = mem[idx];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        mem[i] <= '1;
      end else if (erase && ((IDX_W'(i) >> BLK_LOG) == blk_sel)) begin
        mem[i] <= '1;
      end else if (we && idx == IDX_W'(i)) begin
        mem[i] <= wdata;
      end
    end
  end

  assert_program_lands_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(idx)] == $past(wdata));

  assert_erase_fills_block_R3: assert property (@(posedge clk) disable iff (rst)
    erase |=> mem[($past(idx) >> BLK_LOG) << BLK_LOG] == '1);

endmodule

// File: rtl/nor_seq_rdmux.sv
module nor_seq_rdmux
  import nor_seq_pkg::*;
#(
  parameter int          BANK_BYTES  = 2,
  parameter int          DEV_BYTES   = 1,
  parameter int          IDX_W       = 7,
  parameter logic [15:0] VENDOR_CODE = 16'h0089,
  parameter logic [15:0] PART_CODE   = 16'h0018,
  parameter logic [7:0]  SIZE_LOG2   = 8'd8
) (
  input  logic [7:0]              op,
  input  logic [7:0]              status,
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [8*BANK_BYTES-1:0] array_word,
  output logic [8*BANK_BYTES-1:0] rd_data
);

  localparam int LANE_W = 8 * DEV_BYTES;
  localparam int LANES  = BANK_BYTES / DEV_BYTES;

  rdsrc_t                  src;
  logic [LANE_W-1:0]       lane_val;
  logic [8*BANK_BYTES-1:0] rep;

  assign src = read_source(op);

  always_comb begin
    case (src)
      SRC_STATUS: lane_val = LANE_W'(status);
      SRC_IDENT: begin
        if (word_idx == IDX_W'(0))      lane_val = LANE_W'(VENDOR_CODE);
        else if (word_idx == IDX_W'(1)) lane_val = LANE_W'(PART_CODE);
        else                            lane_val = '0;
      end
      SRC_QUERY: lane_val = LANE_W'(query_byte(8'(word_idx), SIZE_LOG2));
      default:   lane_val = '0;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rep[g*LANE_W +: LANE_W] = lane_val;
  end

  assign rd_data = (src == SRC_ARRAY) ? array_word : rep;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          BANK_BYTES  = 2,
  parameter int          DEV_BYTES   = 1,
  parameter int          ADDR_W      = 8,
  parameter int          BLOCK_BYTES = 32,
  parameter logic [15:0] VENDOR_CODE = 16'h0089,
  parameter logic [15:0] PART_CODE   = 16'h0018
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [8*BANK_BYTES-1:0] wr_data,
  input  logic                    wp,
  output logic [8*BANK_BYTES-1:0] rd_data
);

  localparam int WORD_W    = 8 * BANK_BYTES;
  localparam int OFS_LOG   = $clog2(BANK_BYTES);
  localparam int DEPTH     = (2 ** ADDR_W) / BANK_BYTES;
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int BLK_WORDS = BLOCK_BYTES / BANK_BYTES;
  localparam int CNT_W     = 8 * DEV_BYTES;

  logic [IDX_W-1:0]  word_idx;
  logic              prog_we, erase_we;
  logic [7:0]        op_q, status_q;
  logic [WORD_W-1:0] array_word;

  assign word_idx = IDX_W'(addr >> OFS_LOG);

  nor_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_byte  (wr_data[7:0]),
    .cnt_in   (wr_data[CNT_W-1:0]),
    .wp       (wp),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .op_q     (op_q),
    .status_q (status_q)
  );

  nor_seq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .BLK_WORDS(BLK_WORDS)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (prog_we),
    .erase (erase_we),
    .idx   (word_idx),
    .wdata (wr_data),
    .rdata (array_word)
  );

  nor_seq_rdmux #(
    .BANK_BYTES  (BANK_BYTES),
    .DEV_BYTES   (DEV_BYTES),
    .IDX_W       (IDX_W),
    .VENDOR_CODE (VENDOR_CODE),
    .PART_CODE   (PART_CODE),
    .SIZE_LOG2   (8'(ADDR_W))
  ) u_rdmux (
    .op         (op_q),
    .status     (status_q),
    .word_idx   (word_idx),
    .array_word (array_word),
    .rd_data    (rd_data)
  );

  assert_aligned_access_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (addr % BANK_BYTES) == 0);

  assert_wp_keeps_array_R6: assert property (@(posedge clk) disable iff (rst)
    (wp && wr_en && op_q == OP_NOP) |=> $stable(array_word));

endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  addr;
  logic [15:0] wr_data;
  logic        wp;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  nor_cmd_seq uut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .wp      (wp),
    .rd_data (rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [15:0] exp);
    addr = a;
    #2;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 array after reset", 8'h04, 16'hFFFF);
    bus_write(8'h00, 16'h0070);
    expect_rd("R1 status after reset", 8'h00, 16'h0000);
    bus_write(8'h00, 16'h00FF);
  endtask

  task automatic t_program;
    bus_write(8'h04, 16'h0040);
    bus_write(8'h04, 16'h1234);
    expect_rd("R5 R10 ready replicated after program", 8'h04, 16'h8080);
    bus_write(8'h04, 16'h00FF);
    expect_rd("R2 program 0x40", 8'h04, 16'h1234);
    bus_write(8'h06, 16'h0010);
    bus_write(8'h06, 16'hBEEF);
    bus_write(8'h06, 16'h00FF);
    expect_rd("R2 program 0x10", 8'h06, 16'hBEEF);
  endtask

  task automatic t_clear;
    bus_write(8'h00, 16'h0050);
    bus_write(8'h00, 16'h0070);
    expect_rd("R7 status cleared", 8'h00, 16'h0000);
    bus_write(8'h00, 16'h00F0);
    expect_rd("R7 0xF0 read array", 8'h04, 16'h1234);
    bus_write(8'h00, 16'h0070);
    bus_write(8'h00, 16'h0000);
    expect_rd("R7 0x00 read array", 8'h06, 16'hBEEF);
  endtask

  task automatic t_erase;
    bus_write(8'h22, 16'h0040);
    bus_write(8'h22, 16'h5555);
    bus_write(8'h40, 16'h0040);
    bus_write(8'h40, 16'hAAAA);
    bus_write(8'h2A, 16'h0020);
    expect_rd("R3 R5 status after erase setup", 8'h22, 16'h8080);
    bus_write(8'h2A, 16'h00D0);
    expect_rd("R3 status after confirm", 8'h22, 16'h8080);
    bus_write(8'h00, 16'h00FF);
    expect_rd("R3 erased block", 8'h22, 16'hFFFF);
    expect_rd("R3 other block kept", 8'h40, 16'hAAAA);
    bus_write(8'h40, 16'h0020);
    bus_write(8'h40, 16'h00FF);
    expect_rd("R3 abort to read array", 8'h40, 16'hFFFF);
    bus_write(8'h70, 16'h0020);
    bus_write(8'h70, 16'h0033);
    expect_rd("R3 bad confirm resets", 8'h04, 16'h1234);
  endtask

  task automatic t_bufwr;
    bus_write(8'h00, 16'h0050);
    bus_write(8'h60, 16'h00E8);
    expect_rd("R5 ready after buffered setup", 8'h60, 16'h8080);
    bus_write(8'h60, 16'h0102);
    bus_write(8'h60, 16'h1111);
    bus_write(8'h62, 16'h2222);
    bus_write(8'h64, 16'h3333);
    bus_write(8'h66, 16'h00D0);
    expect_rd("R4 status after confirm", 8'h60, 16'h8080);
    bus_write(8'h00, 16'h00FF);
    expect_rd("R4 word 0", 8'h60, 16'h1111);
    expect_rd("R4 word 1", 8'h62, 16'h2222);
    expect_rd("R4 word 2", 8'h64, 16'h3333);
    expect_rd("R4 confirm not stored", 8'h66, 16'hFFFF);
    bus_write(8'h68, 16'h00E8);
    bus_write(8'h68, 16'h0000);
    bus_write(8'h68, 16'h5A5A);
    bus_write(8'h6A, 16'h0077);
    expect_rd("R4 single word stored", 8'h68, 16'h5A5A);
    expect_rd("R4 bad confirm not stored", 8'h6A, 16'hFFFF);
  endtask

  task automatic t_protect;
    wp = 1'b1;
    bus_write(8'h00, 16'h0050);
    bus_write(8'h08, 16'h0040);
    bus_write(8'h08, 16'h7777);
    expect_rd("R6 program error", 8'h08, 16'h9090);
    bus_write(8'h00, 16'h00FF);
    expect_rd("R6 program blocked", 8'h08, 16'hFFFF);
    bus_write(8'h00, 16'h0050);
    bus_write(8'h00, 16'h0020);
    bus_write(8'h00, 16'h00D0);
    expect_rd("R6 erase error", 8'h00, 16'hA0A0);
    bus_write(8'h00, 16'h00FF);
    expect_rd("R6 erase blocked", 8'h04, 16'h1234);
    bus_write(8'h00, 16'h0050);
    bus_write(8'h0A, 16'h00E8);
    bus_write(8'h0A, 16'h0000);
    bus_write(8'h0A, 16'h4444);
    expect_rd("R6 buffered error", 8'h0A, 16'h9090);
    bus_write(8'h0A, 16'h00D0);
    bus_write(8'h00, 16'h00FF);
    expect_rd("R6 buffered blocked", 8'h0A, 16'hFFFF);
    wp = 1'b0;
    bus_write(8'h00, 16'h0050);
  endtask

  task automatic t_ident;
    bus_write(8'h00, 16'h0090);
    expect_rd("R8 vendor code", 8'h00, 16'h8989);
    expect_rd("R8 part code", 8'h02, 16'h1818);
    expect_rd("R8 other index", 8'h04, 16'h0000);
    bus_write(8'h00, 16'h0070);
    expect_rd("R8 status after id", 8'h04, 16'h0000);
    bus_write(8'h00, 16'h0090);
    bus_write(8'h00, 16'h0050);
    expect_rd("R8 command after id", 8'h04, 16'h1234);
  endtask

  task automatic t_lock;
    bus_write(8'h00, 16'h0060);
    bus_write(8'h00, 16'h0001);
    expect_rd("R9 lock set 0x01", 8'h00, 16'h8080);
    bus_write(8'h00, 16'h0050);
    bus_write(8'h00, 16'h0060);
    bus_write(8'h00, 16'h00D0);
    expect_rd("R9 lock 0xD0", 8'h00, 16'h8080);
    bus_write(8'h00, 16'h0050);
    bus_write(8'h00, 16'h0060);
    bus_write(8'h00, 16'h0077);
    expect_rd("R9 lock bad value", 8'h04, 16'h1234);
  endtask

  task automatic t_unknown;
    bus_write(8'h00, 16'h0070);
    bus_write(8'h00, 16'h0033);
    expect_rd("R11 unknown after status", 8'h04, 16'h1234);
    bus_write(8'h00, 16'h00C5);
    expect_rd("R11 unknown from idle", 8'h06, 16'hBEEF);
  endtask

  task automatic t_query;
    bus_write(8'h00, 16'h0098);
    expect_rd("R12 query Q", 8'h20, 16'h5151);
    expect_rd("R12 query R", 8'h22, 16'h5252);
    expect_rd("R12 query Y", 8'h24, 16'h5959);
    expect_rd("R12 size field", 8'h4E, 16'h0808);
    bus_write(8'h00, 16'h0012);
    expect_rd("R12 stays in query", 8'h20, 16'h5151);
    bus_write(8'h00, 16'h00FF);
    expect_rd("R12 leave query", 8'h04, 16'h1234);
  endtask

  initial begin
    rst = 1'b1;
    wr_en = 1'b0;
    addr = '0;
    wr_data = '0;
    wp = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_program();
    t_clear();
    t_erase();
    t_bufwr();
    t_protect();
    t_ident();
    t_lock();
    t_unknown();
    t_query();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule